// File: doc/BRIEF.md
# Tagless Reservation Station Scheduler

This block is the waiting room of a queue-based out-of-order core. Decoded instructions arrive in groups of up to four. Each one names two source locations and one destination location in a circular operand queue. The block reads whichever source values are already present, parks each instruction in a free slot, and sends it to its functional unit once both operands are present and the unit reports that it is not busy. There are four units: load/store, adder, multiplier and divider.

The block also owns the operand queue. Each functional unit returns results on its own result port, and each result carries a destination queue address. A returning result is written into the queue at that address. In the same edge, every parked instruction whose source address equals that destination captures the value. Dependencies are found by comparing queue addresses, so there are no rename tags and no reorder buffer. Among ready instructions that compete for one unit, the oldest is sent first. A younger ready instruction still overtakes an older one that is stalled.

Top module: `tagless_rs`

## Requirements
- R1: After reset the station holds no instructions and `alloc_ready_o` is high. No issue port is valid. Every operand queue location is present and reads as zero.
- R2: `alloc_ready_o` is high only while at least four station slots are free. A group is accepted at an edge where `alloc_ready_o` is high and at least one `alloc_valid_i` bit is set. Slots whose valid bit is low are ignored, and a group offered while `alloc_ready_o` is low is dropped.
- R3: Opcode bits [3:2] select the unit: 0 is load/store, 1 is the adder, 2 is the multiplier and 3 is the divider. The instruction issues only on that unit's port. It presents its full opcode, the value at source A on `iss_opa_o`, the value at source B on `iss_opb_o`, and its destination address.
- R4: An instruction issues only when both of its operands are present and the target unit's busy input was low at the selecting edge. The issue port goes valid for exactly one cycle, after that edge. Until then the instruction stays parked.
- R5: Among ready instructions for the same unit, the one allocated earliest issues first. Within a group, lower slot numbers count as older. A ready instruction issues ahead of an older instruction that is not ready.
- R6: A valid result on any unit's result port writes its data at its destination address. The value can be read on `q_rd_data_o` one cycle after `q_rd_addr_i` selects it. Results on different unit ports in the same cycle all take effect.
- R7: A parked instruction waiting on a source address captures the data of a result whose destination equals that address, at the edge of the broadcast. It can issue at the next edge.
- R8: Accepting an instruction marks its destination location as not present. Until a result is written there, later instructions that read that location wait.
- R9: A result that arrives at the same edge as an allocation whose source matches its destination supplies that operand directly.
- R10: A source equal to the destination of a lower-numbered valid slot in the same group is treated as not present.
- R11: Up to four instructions issue at one edge, one on each unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid_i | input | 4 | Per-slot valid of the incoming group |
| alloc_opc_i | input | 4x4 | Per-slot opcode; bits [3:2] pick the unit |
| alloc_srca_i | input | 4x4 | Per-slot queue address of operand A |
| alloc_srcb_i | input | 4x4 | Per-slot queue address of operand B |
| alloc_dst_i | input | 4x4 | Per-slot destination queue address |
| alloc_ready_o | output | 1 | Station can take a full group |
| fu_busy_i | input | 4 | Per-unit busy |
| iss_valid_o | output | 4 | Per-unit issue strobe |
| iss_opc_o | output | 4x4 | Issued opcode per unit |
| iss_opa_o | output | 4x16 | Issued operand A per unit |
| iss_opb_o | output | 4x16 | Issued operand B per unit |
| iss_dst_o | output | 4x4 | Issued destination per unit |
| res_valid_i | input | 4 | Per-unit result valid |
| res_dst_i | input | 4x4 | Per-unit result destination address |
| res_data_i | input | 4x16 | Per-unit result data |
| q_rd_addr_i | input | 4 | Operand queue read address |
| q_rd_data_o | output | 16 | Registered operand queue read data |

## Verification
The checks assume a legal queue program. At any time, at most one parked or in-flight instruction owns a given destination address, and no two unit ports return results to the same address in the same cycle. The stimulus keeps to this by giving every destination a distinct address within a test. After every test it returns each destination to its initial value through a result port, before that address is used again. Busy inputs change only between edges, and each unit's result port carries at most one result per cycle. This matches what the issue-to-free-unit property takes for granted.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // default geometry of the station
  localparam int RS_DATA_W  = 16;
  localparam int RS_QADDR_W = 4;
  localparam int RS_OPC_W   = 4;
  localparam int RS_DEPTH   = 8;
  localparam int RS_ALLOC_W = 4;
  localparam int RS_NUM_FU  = 4;
  // unit numbering carried in the top opcode bits
  localparam int FU_LDST = 0;
  localparam int FU_ADD  = 1;
  localparam int FU_MUL  = 2;
  localparam int FU_DIV  = 3;
endpackage

// File: rtl/rs_qfile.sv
module rs_qfile #(
  parameter int DATA_W  = 16,
  parameter int QADDR_W = 4,
  parameter int NWR     = 4,
  parameter int NCLR    = 4,
  parameter int NRD     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NWR-1:0]                 wr_en,
  input  logic [NWR-1:0][QADDR_W-1:0]    wr_addr,
  input  logic [NWR-1:0][DATA_W-1:0]     wr_data,
  input  logic [NCLR-1:0]                clr_en,
  input  logic [NCLR-1:0][QADDR_W-1:0]   clr_addr,
  input  logic [NRD-1:0][QADDR_W-1:0]    rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]     rd_data,
  output logic [NRD-1:0]                 rd_vld,
  input  logic [QADDR_W-1:0]             dbg_addr,
  output logic [DATA_W-1:0]              dbg_data
);
  localparam int QDEPTH = 1 << QADDR_W;

  logic [QDEPTH-1:0][DATA_W-1:0] q_data;
  logic [QDEPTH-1:0]             q_vld;
  logic [NWR-1:0]                clr_hit;

  // pending marks from new allocations override a same-edge write
  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
      q_vld  <= '1;
    end else begin
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w]) begin
          q_data[wr_addr[w]] <= wr_data[w];
          q_vld[wr_addr[w]]  <= 1'b1;
        end
      end
      for (int c = 0; c < NCLR; c++) begin
        if (clr_en[c]) q_vld[clr_addr[c]] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_data[r] = q_data[rd_addr[r]];
      rd_vld[r]  = q_vld[rd_addr[r]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= q_data[dbg_addr];
  end

  always_comb begin
    for (int w = 0; w < NWR; w++) begin
      clr_hit[w] = 1'b0;
      for (int c = 0; c < NCLR; c++)
        if (clr_en[c] && clr_addr[c] == wr_addr[w]) clr_hit[w] = 1'b1;
    end
  end

  for (genvar w = 0; w < NWR; w++) begin : g_wr_chk
    AST_WRITE_MAKES_PRESENT: assert property (@(posedge clk) disable iff (rst)
      wr_en[w] && !clr_hit[w] |=> q_vld[$past(wr_addr[w])]); // R6
  end
endmodule

// File: rtl/rs_slot_map.sv
module rs_slot_map #(
  parameter int RS_DEPTH = 8,
  parameter int ALLOC_W  = 4,
  localparam int SLOT_W  = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1
) (
  input  logic [ALLOC_W-1:0]             slot_valid,
  input  logic [RS_DEPTH-1:0]            ent_busy,
  output logic [RS_DEPTH-1:0]            ent_take,
  output logic [RS_DEPTH-1:0][SLOT_W-1:0] ent_slot,
  output logic                           room
);
  int slot_rank [ALLOC_W];
  int n_valid;
  int free_rank;

  // k-th valid slot goes to the k-th free entry, counted from index 0
  always_comb begin
    n_valid = 0;
    for (int k = 0; k < ALLOC_W; k++) begin
      slot_rank[k] = n_valid;
      if (slot_valid[k]) n_valid = n_valid + 1;
    end
    free_rank = 0;
    for (int i = 0; i < RS_DEPTH; i++) begin
      ent_take[i] = 1'b0;
      ent_slot[i] = '0;
      if (!ent_busy[i]) begin
        if (free_rank < n_valid) ent_take[i] = 1'b1;
        for (int k = 0; k < ALLOC_W; k++)
          if (slot_valid[k] && slot_rank[k] == free_rank) ent_slot[i] = SLOT_W'(k);
        free_rank = free_rank + 1;
      end
    end
    room = (free_rank >= ALLOC_W);
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int RS_DEPTH = 8,
  parameter int NUM_FU   = 4,
  localparam int FU_SEL_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [RS_DEPTH-1:0]               ent_vld,
  input  logic [RS_DEPTH-1:0]               alloc_we,
  input  logic [RS_DEPTH-1:0]               req,
  input  logic [RS_DEPTH-1:0][FU_SEL_W-1:0] fu_sel,
  input  logic [NUM_FU-1:0]                 fu_free,
  output logic [NUM_FU-1:0][RS_DEPTH-1:0]   grant,
  output logic [RS_DEPTH-1:0]               grant_any
);
  // older[i][j] set: entry j was allocated before entry i
  logic [RS_DEPTH-1:0][RS_DEPTH-1:0] older;
  logic [NUM_FU-1:0][RS_DEPTH-1:0]   compete;

  always_ff @(posedge clk) begin
    if (rst) begin
      older <= '0;
    end else begin
      for (int i = 0; i < RS_DEPTH; i++) begin
        for (int j = 0; j < RS_DEPTH; j++) begin
          if (alloc_we[i])      older[i][j] <= ent_vld[j] || (alloc_we[j] && j < i);
          else if (alloc_we[j]) older[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    grant_any = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      for (int j = 0; j < RS_DEPTH; j++)
        compete[f][j] = req[j] && (fu_sel[j] == FU_SEL_W'(f));
      for (int i = 0; i < RS_DEPTH; i++) begin
        grant[f][i] = fu_free[f] && compete[f][i] && ((older[i] & compete[f]) == '0);
        grant_any[i] = grant_any[i] | grant[f][i];
      end
    end
  end

  for (genvar f = 0; f < NUM_FU; f++) begin : g_grant_chk
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[f])); // R5
  end
endmodule

// File: rtl/tagless_rs.sv
module tagless_rs #(
  parameter int DATA_W   = rs_pkg::RS_DATA_W,
  parameter int QADDR_W  = rs_pkg::RS_QADDR_W,
  parameter int OPC_W    = rs_pkg::RS_OPC_W,
  parameter int RS_DEPTH = rs_pkg::RS_DEPTH,
  parameter int ALLOC_W  = rs_pkg::RS_ALLOC_W,
  parameter int NUM_FU   = rs_pkg::RS_NUM_FU
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ALLOC_W-1:0]              alloc_valid_i,
  input  logic [ALLOC_W-1:0][OPC_W-1:0]   alloc_opc_i,
  input  logic [ALLOC_W-1:0][QADDR_W-1:0] alloc_srca_i,
  input  logic [ALLOC_W-1:0][QADDR_W-1:0] alloc_srcb_i,
  input  logic [ALLOC_W-1:0][QADDR_W-1:0] alloc_dst_i,
  output logic                            alloc_ready_o,
  input  logic [NUM_FU-1:0]               fu_busy_i,
  output logic [NUM_FU-1:0]               iss_valid_o,
  output logic [NUM_FU-1:0][OPC_W-1:0]    iss_opc_o,
  output logic [NUM_FU-1:0][DATA_W-1:0]   iss_opa_o,
  output logic [NUM_FU-1:0][DATA_W-1:0]   iss_opb_o,
  output logic [NUM_FU-1:0][QADDR_W-1:0]  iss_dst_o,
  input  logic [NUM_FU-1:0]               res_valid_i,
  input  logic [NUM_FU-1:0][QADDR_W-1:0]  res_dst_i,
  input  logic [NUM_FU-1:0][DATA_W-1:0]   res_data_i,
  input  logic [QADDR_W-1:0]              q_rd_addr_i,
  output logic [DATA_W-1:0]               q_rd_data_o
);
  localparam int FU_SEL_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1;
  localparam int SLOT_W   = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;
  localparam int NRD      = 2 * ALLOC_W;

  // parked entries
  logic [RS_DEPTH-1:0]               ent_vld;
  logic [RS_DEPTH-1:0][OPC_W-1:0]    ent_opc;
  logic [RS_DEPTH-1:0][FU_SEL_W-1:0] ent_fu;
  logic [RS_DEPTH-1:0][QADDR_W-1:0]  ent_sa, ent_sb, ent_dst;
  logic [RS_DEPTH-1:0]               ent_va, ent_vb;
  logic [RS_DEPTH-1:0][DATA_W-1:0]   ent_da, ent_db;

  logic [RS_DEPTH-1:0]               wk_va, wk_vb;
  logic [RS_DEPTH-1:0][DATA_W-1:0]   wk_da, wk_db;

  logic [ALLOC_W-1:0]                slot_va, slot_vb;
  logic [ALLOC_W-1:0][DATA_W-1:0]    slot_da, slot_db;

  logic [NRD-1:0][QADDR_W-1:0]       qf_rd_addr;
  logic [NRD-1:0][DATA_W-1:0]        qf_rd_data;
  logic [NRD-1:0]                    qf_rd_vld;

  logic [RS_DEPTH-1:0]               take;
  logic [RS_DEPTH-1:0][SLOT_W-1:0]   ent_slot;
  logic                              room;
  logic                              fire;
  logic [ALLOC_W-1:0]                clr_en;
  logic [RS_DEPTH-1:0]               alloc_we;
  logic [RS_DEPTH-1:0]               req;
  logic [NUM_FU-1:0][RS_DEPTH-1:0]   grant;
  logic [RS_DEPTH-1:0]               grant_any;

  logic [NUM_FU-1:0][OPC_W-1:0]      nx_opc;
  logic [NUM_FU-1:0][DATA_W-1:0]     nx_opa, nx_opb;
  logic [NUM_FU-1:0][QADDR_W-1:0]    nx_dst;

  assign alloc_ready_o = room;
  assign fire          = room && (|alloc_valid_i);
  assign clr_en        = alloc_valid_i & {ALLOC_W{fire}};
  assign alloc_we      = take & {RS_DEPTH{fire}};
  assign req           = ent_vld & ent_va & ent_vb;

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_rd_map
    assign qf_rd_addr[k]           = alloc_srca_i[k];
    assign qf_rd_addr[ALLOC_W + k] = alloc_srcb_i[k];
  end

  rs_qfile #(
    .DATA_W (DATA_W),
    .QADDR_W(QADDR_W),
    .NWR    (NUM_FU),
    .NCLR   (ALLOC_W),
    .NRD    (NRD)
  ) i_qfile (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (res_valid_i),
    .wr_addr (res_dst_i),
    .wr_data (res_data_i),
    .clr_en  (clr_en),
    .clr_addr(alloc_dst_i),
    .rd_addr (qf_rd_addr),
    .rd_data (qf_rd_data),
    .rd_vld  (qf_rd_vld),
    .dbg_addr(q_rd_addr_i),
    .dbg_data(q_rd_data_o)
  );

  rs_slot_map #(
    .RS_DEPTH(RS_DEPTH),
    .ALLOC_W (ALLOC_W)
  ) i_slot_map (
    .slot_valid(alloc_valid_i),
    .ent_busy  (ent_vld),
    .ent_take  (take),
    .ent_slot  (ent_slot),
    .room      (room)
  );

  rs_age_pick #(
    .RS_DEPTH(RS_DEPTH),
    .NUM_FU  (NUM_FU)
  ) i_age_pick (
    .clk      (clk),
    .rst      (rst),
    .ent_vld  (ent_vld),
    .alloc_we (alloc_we),
    .req      (req),
    .fu_sel   (ent_fu),
    .fu_free  (~fu_busy_i),
    .grant    (grant),
    .grant_any(grant_any)
  );

  // operand resolution for incoming slots: queue, then same-edge result,
  // then an older producer in the same group, which wins
  always_comb begin
    for (int k = 0; k < ALLOC_W; k++) begin
      slot_va[k] = qf_rd_vld[k];
      slot_da[k] = qf_rd_data[k];
      slot_vb[k] = qf_rd_vld[ALLOC_W + k];
      slot_db[k] = qf_rd_data[ALLOC_W + k];
      for (int f = 0; f < NUM_FU; f++) begin
        if (res_valid_i[f] && res_dst_i[f] == alloc_srca_i[k]) begin
          slot_va[k] = 1'b1;
          slot_da[k] = res_data_i[f];
        end
        if (res_valid_i[f] && res_dst_i[f] == alloc_srcb_i[k]) begin
          slot_vb[k] = 1'b1;
          slot_db[k] = res_data_i[f];
        end
      end
      for (int j = 0; j < ALLOC_W; j++) begin
        if (j < k && alloc_valid_i[j] && alloc_dst_i[j] == alloc_srca_i[k]) slot_va[k] = 1'b0;
        if (j < k && alloc_valid_i[j] && alloc_dst_i[j] == alloc_srcb_i[k]) slot_vb[k] = 1'b0;
      end
    end
  end

  // wakeup of parked entries by address match on the result ports
  always_comb begin
    for (int i = 0; i < RS_DEPTH; i++) begin
      wk_va[i] = ent_va[i];
      wk_da[i] = ent_da[i];
      wk_vb[i] = ent_vb[i];
      wk_db[i] = ent_db[i];
      for (int f = 0; f < NUM_FU; f++) begin
        if (!ent_va[i] && res_valid_i[f] && res_dst_i[f] == ent_sa[i]) begin
          wk_va[i] = 1'b1;
          wk_da[i] = res_data_i[f];
        end
        if (!ent_vb[i] && res_valid_i[f] && res_dst_i[f] == ent_sb[i]) begin
          wk_vb[i] = 1'b1;
          wk_db[i] = res_data_i[f];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else begin
      for (int i = 0; i < RS_DEPTH; i++) begin
        if (alloc_we[i]) begin
          ent_vld[i] <= 1'b1;
          ent_opc[i] <= alloc_opc_i[ent_slot[i]];
          ent_fu[i]  <= alloc_opc_i[ent_slot[i]][OPC_W-1 -: FU_SEL_W];
          ent_sa[i]  <= alloc_srca_i[ent_slot[i]];
          ent_sb[i]  <= alloc_srcb_i[ent_slot[i]];
          ent_dst[i] <= alloc_dst_i[ent_slot[i]];
          ent_va[i]  <= slot_va[ent_slot[i]];
          ent_da[i]  <= slot_da[ent_slot[i]];
          ent_vb[i]  <= slot_vb[ent_slot[i]];
          ent_db[i]  <= slot_db[ent_slot[i]];
        end else begin
          if (grant_any[i]) ent_vld[i] <= 1'b0;
          ent_va[i] <= wk_va[i];
          ent_da[i] <= wk_da[i];
          ent_vb[i] <= wk_vb[i];
          ent_db[i] <= wk_db[i];
        end
      end
    end
  end

  // one-hot grant selects the winner's fields for each unit
  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      nx_opc[f] = '0;
      nx_opa[f] = '0;
      nx_opb[f] = '0;
      nx_dst[f] = '0;
      for (int i = 0; i < RS_DEPTH; i++) begin
        if (grant[f][i]) begin
          nx_opc[f] = nx_opc[f] | ent_opc[i];
          nx_opa[f] = nx_opa[f] | ent_da[i];
          nx_opb[f] = nx_opb[f] | ent_db[i];
          nx_dst[f] = nx_dst[f] | ent_dst[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid_o <= '0;
      iss_opc_o   <= '0;
      iss_opa_o   <= '0;
      iss_opb_o   <= '0;
      iss_dst_o   <= '0;
    end else begin
      for (int f = 0; f < NUM_FU; f++) begin
        iss_valid_o[f] <= |grant[f];
        iss_opc_o[f]   <= nx_opc[f];
        iss_opa_o[f]   <= nx_opa[f];
        iss_opb_o[f]   <= nx_opb[f];
        iss_dst_o[f]   <= nx_dst[f];
      end
    end
  end

  AST_GROUP_FITS: assert property (@(posedge clk) disable iff (rst)
    fire |-> $countones(take) == $countones(alloc_valid_i)); // R2

  for (genvar f = 0; f < NUM_FU; f++) begin : g_iss_chk
    AST_ISSUE_TO_FREE_UNIT: assert property (@(posedge clk) disable iff (rst)
      iss_valid_o[f] |-> !$past(fu_busy_i[f])); // R4
  end

  for (genvar i = 0; i < RS_DEPTH; i++) begin : g_ent_chk
    AST_PARKED_UNTIL_GRANT: assert property (@(posedge clk) disable iff (rst)
      ent_vld[i] && !grant_any[i] |=> ent_vld[i]); // R4
  end
endmodule

// File: tb/test_tagless_rs.sv
`timescale 1ns/1ps
module test_tagless_rs;
  import rs_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [3:0]           alloc_valid = '0;
  logic [3:0][3:0]      alloc_opc = '0;
  logic [3:0][3:0]      alloc_srca = '0;
  logic [3:0][3:0]      alloc_srcb = '0;
  logic [3:0][3:0]      alloc_dst = '0;
  logic                 alloc_ready;
  logic [3:0]           fu_busy = '0;
  logic [3:0]           iss_valid;
  logic [3:0][3:0]      iss_opc;
  logic [3:0][15:0]     iss_opa;
  logic [3:0][15:0]     iss_opb;
  logic [3:0][3:0]      iss_dst;
  logic [3:0]           res_valid = '0;
  logic [3:0][3:0]      res_dst = '0;
  logic [3:0][15:0]     res_data = '0;
  logic [3:0]           q_rd_addr = '0;
  logic [15:0]          q_rd_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tagless_rs i_tagless_rs (
    .clk(clk), .rst(rst),
    .alloc_valid_i(alloc_valid), .alloc_opc_i(alloc_opc),
    .alloc_srca_i(alloc_srca), .alloc_srcb_i(alloc_srcb), .alloc_dst_i(alloc_dst),
    .alloc_ready_o(alloc_ready), .fu_busy_i(fu_busy),
    .iss_valid_o(iss_valid), .iss_opc_o(iss_opc), .iss_opa_o(iss_opa),
    .iss_opb_o(iss_opb), .iss_dst_o(iss_dst),
    .res_valid_i(res_valid), .res_dst_i(res_dst), .res_data_i(res_data),
    .q_rd_addr_i(q_rd_addr), .q_rd_data_o(q_rd_data)
  );

  function automatic int qinit(int a);
    return a * 3 + 1;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_slot(int k, int opc, int sa, int sb, int d);
    alloc_valid[k] = 1'b1;
    alloc_opc[k]   = 4'(opc);
    alloc_srca[k]  = 4'(sa);
    alloc_srcb[k]  = 4'(sb);
    alloc_dst[k]   = 4'(d);
  endtask

  task automatic put_res(int f, int d, int v);
    res_valid[f] = 1'b1;
    res_dst[f]   = 4'(d);
    res_data[f]  = 16'(v);
  endtask

  task automatic restore(int a);
    put_res(0, a, qinit(a));
    step();
    res_valid = '0;
  endtask

  task automatic read_q(int a, string tag, int exp);
    q_rd_addr = 4'(a);
    step();
    chk(tag, int'(q_rd_data), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int seen;
    int hit5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 iss_valid", int'(iss_valid), 0);
    read_q(5, "R1 queue zero", 0);

    // R6 fill the whole queue, four ports per cycle, then read back
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 4; f++) put_res(f, c * 4 + f, qinit(c * 4 + f));
      step();
      res_valid = '0;
    end
    for (int a = 0; a < 16; a++) read_q(a, "R6 queue readback", qinit(a));

    // R3 every opcode once, operands read from the queue
    for (int a = 0; a < 16; a++) begin
      put_slot(0, a, a, (a + 5) % 16, (a + 9) % 16);
      step();
      alloc_valid = '0;
      step();
      chk("R3 unit select", int'(iss_valid), 1 << (a / 4));
      chk("R3 opcode", int'(iss_opc[a / 4]), a);
      chk("R3 operand A", int'(iss_opa[a / 4]), qinit(a));
      chk("R3 operand B", int'(iss_opb[a / 4]), qinit((a + 5) % 16));
      chk("R3 dest", int'(iss_dst[a / 4]), (a + 9) % 16);
      restore((a + 9) % 16);
    end

    // R10 in-group dependency, R7 wakeup by address
    put_slot(0, 4'b0100, 1, 2, 3);
    put_slot(1, 4'b1000, 3, 1, 4);
    step();
    alloc_valid = '0;
    step();
    chk("R10 producer issues", int'(iss_valid), 4'b0010);
    chk("R10 producer A", int'(iss_opa[FU_ADD]), qinit(1));
    put_res(FU_ADD, 3, 100);
    step();
    res_valid = '0;
    chk("R10 consumer held", int'(iss_valid[FU_MUL]), 0);
    step();
    chk("R7 consumer issues", int'(iss_valid), 4'b0100);
    chk("R7 captured A", int'(iss_opa[FU_MUL]), 100);
    chk("R7 B", int'(iss_opb[FU_MUL]), qinit(1));
    read_q(3, "R6 result written", 100);
    restore(3);
    restore(4);

    // R4 busy hold, R5 oldest first
    fu_busy[FU_ADD] = 1'b1;
    put_slot(0, 4'b0100, 5, 6, 10);
    put_slot(1, 4'b0110, 6, 7, 11);
    step();
    alloc_valid = '0;
    step();
    chk("R4 busy blocks", int'(iss_valid), 0);
    step();
    chk("R4 busy blocks", int'(iss_valid), 0);
    fu_busy[FU_ADD] = 1'b0;
    step();
    chk("R5 oldest dest", int'(iss_dst[FU_ADD]), 10);
    chk("R5 oldest A", int'(iss_opa[FU_ADD]), qinit(5));
    step();
    chk("R5 next dest", int'(iss_dst[FU_ADD]), 11);
    chk("R5 next opcode", int'(iss_opc[FU_ADD]), 4'b0110);
    step();
    chk("R4 one-cycle pulse", int'(iss_valid), 0);
    restore(10);
    restore(11);

    // R5 younger ready passes stalled older, R8 pending across groups
    fu_busy[FU_LDST] = 1'b1;
    put_slot(0, 4'b0000, 0, 0, 13);
    put_slot(1, 4'b0100, 13, 0, 14);
    put_slot(2, 4'b0101, 1, 2, 15);
    step();
    alloc_valid = '0;
    step();
    chk("R5 younger passes", int'(iss_valid), 4'b0010);
    chk("R5 younger dest", int'(iss_dst[FU_ADD]), 15);
    put_slot(0, 4'b0111, 13, 1, 12);
    step();
    alloc_valid = '0;
    step();
    chk("R8 pending waits", int'(iss_valid), 0);
    fu_busy[FU_LDST] = 1'b0;
    step();
    chk("R4 load issues", int'(iss_valid), 4'b0001);
    chk("R4 load dest", int'(iss_dst[FU_LDST]), 13);
    put_res(FU_LDST, 13, 77);
    step();
    res_valid = '0;
    step();
    chk("R7 older waiter dest", int'(iss_dst[FU_ADD]), 14);
    chk("R7 older waiter A", int'(iss_opa[FU_ADD]), 77);
    chk("R7 older waiter B", int'(iss_opb[FU_ADD]), qinit(0));
    step();
    chk("R8 later waiter dest", int'(iss_dst[FU_ADD]), 12);
    chk("R8 later waiter A", int'(iss_opa[FU_ADD]), 77);
    for (int a = 12; a < 16; a++) restore(a);

    // R9 bypass at allocation
    put_slot(0, 4'b1000, 6, 7, 8);
    put_res(FU_DIV, 6, 555);
    step();
    alloc_valid = '0;
    res_valid = '0;
    step();
    chk("R9 bypass issues", int'(iss_valid), 4'b0100);
    chk("R9 bypass A", int'(iss_opa[FU_MUL]), 555);
    chk("R9 bypass B", int'(iss_opb[FU_MUL]), qinit(7));
    restore(6);
    restore(8);

    // R2 capacity, R11 four issues at once
    fu_busy = '1;
    for (int k = 0; k < 4; k++) put_slot(k, 4'b0100, 1, 2, 8 + k);
    step();
    alloc_valid = '0;
    chk("R2 room after four", int'(alloc_ready), 1);
    for (int k = 0; k < 4; k++) put_slot(k, k * 4, 1, 2, 12 + k);
    step();
    alloc_valid = '0;
    chk("R2 full", int'(alloc_ready), 0);
    put_slot(0, 4'b0100, 1, 2, 5);
    step();
    alloc_valid = '0;
    chk("R2 still full", int'(alloc_ready), 0);
    fu_busy = '0;
    step();
    chk("R11 four units", int'(iss_valid), 4'b1111);
    chk("R11 adder oldest", int'(iss_dst[FU_ADD]), 8);
    chk("R11 divider dest", int'(iss_dst[FU_DIV]), 15);
    seen = 4;
    hit5 = 0;
    for (int c = 0; c < 8; c++) begin
      step();
      seen += $countones(iss_valid);
      for (int f = 0; f < 4; f++)
        if (iss_valid[f] && iss_dst[f] == 4'd5) hit5 = 1;
    end
    chk("R2 issued total", seen, 8);
    chk("R2 dropped group", hit5, 0);
    chk("R2 drained", int'(alloc_ready), 1);
    read_q(5, "R2 dropped dest untouched", qinit(5));
    for (int a = 8; a < 16; a++) restore(a);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule